// File: doc/BRIEF.md
# Cross-Page Branch Target Translator

This unit resolves the destination of a branch that leaves the current guest page when the program runs as translated code. The branch supplies a base register value and an offset. Their sum is a guest effective address. The upper part of that address is looked up in a small instruction-side translation buffer. Each entry of that buffer maps a guest 4 KB virtual page directly to the real frame that holds the page's translated code. That frame is 2^LOG2N times larger than the guest page, 16 KB at the default expansion of four. While the lookup runs, the 12-bit page offset is shifted left by LOG2N to form the instruction-cache index.

A translated target is fetched optimistically one cycle after the request. In the cycle after that fetch, the cache returns the entry marker of the fetched bundle. The final outcome is either a target real address or an exception code. A miss in the buffer raises a separate micro-interrupt flag so that software can refill the entry through the fill port. Short branches inside a page, and branches through a link register or a long offset, take the bypass path. These skip both the lookup and the entry check.

Top module: `xpage_target_unit`

## Requirements
- R1: After reset, `fetch_valid` and `done_valid` are 0 and every buffer slot is empty, so the first translated request reports a miss.
- R2: The guest page number is `req_base[31:12] + req_ofs[31:12]`. The page offset is the bitwise OR of the two low 12-bit fields, with no carry into the page number.
- R3: For a buffer hit whose page is both mapped and translated, the target real address is `{frame, page_offset, 2'b00}`, which equals frame × 16 KB + offset × 4. `fetch_index` is the low 14 bits of that address.
- R4: Every request yields `done_valid` exactly two cycles later. A request that needs a fetch raises `fetch_valid` with the target one cycle after the request.
- R5: On a buffer miss, `done_miss` is 1, `done_exc` is 0 (none), `done_addr` is 0 and no fetch is issued.
- R6: A hit on an entry marked unmapped gives `done_exc` = 1 (guest page fault) with no fetch, whatever the translated flag says.
- R7: A hit on an entry that is mapped but not translated gives `done_exc` = 2 (translation missing) with no fetch.
- R8: For a fetched translated target, `entry_mark` is sampled in the cycle when `fetch_valid` is high. If it is 0, the outcome is `done_exc` = 3 (invalid entry) and `done_addr` keeps the target. If it is 1, the outcome is `done_exc` = 0.
- R9: With `req_bypass` = 1, the target is the full 32-bit sum `req_base + req_ofs`, fetched unconditionally. The outcome is `done_exc` = 0 and `done_miss` = 0, whatever the buffer holds and whatever `entry_mark` is.
- R10: A fill writes slot `fill_slot` with the page number, flags and frame given. A request in the same cycle as the fill sees the previous contents of the slot. When several valid slots match, the lowest-numbered one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Branch request strobe |
| req_bypass | input | 1 | Request takes the bypass path (no lookup, no entry check) |
| req_base | input | 32 | Base register value |
| req_ofs | input | 32 | Branch offset |
| fill_we | input | 1 | Buffer write strobe |
| fill_slot | input | 2 | Slot written by a fill |
| fill_vpn | input | 20 | Guest virtual page number for the slot |
| fill_mapped | input | 1 | Guest page has a physical mapping |
| fill_xlated | input | 1 | Translated code exists for the page |
| fill_frame | input | 18 | Real 16 KB frame number of the translated code |
| fetch_valid | output | 1 | Optimistic fetch of the target is issued |
| fetch_addr | output | 32 | Real address being fetched |
| fetch_index | output | 14 | Instruction-cache index for the fetch |
| entry_mark | input | 1 | Entry marker of the fetched bundle, valid while `fetch_valid` is high |
| done_valid | output | 1 | Outcome valid |
| done_addr | output | 32 | Resolved target real address, or 0 when nothing was fetched |
| done_exc | output | 2 | 0 none, 1 page fault, 2 translation missing, 3 invalid entry |
| done_miss | output | 1 | Buffer-miss micro-interrupt |

## Verification
A corrupted buffer slot shows up on the next request that touches its page. The error is visible one cycle later as a wrong `fetch_addr` or a missing fetch, and two cycles later as a wrong exception code or a wrong miss flag. A fault in the offset path, such as a carry or a wrong shift, corrupts the low bits of `fetch_index` and `done_addr` for almost every offset. For that reason the page offset is swept across its extremes and across interior values, with the low bits supplied by the base register in some requests and by the offset in others. The exception-order cases combine the mapped and translated flags with both marker values. Those cases expose a wrong priority within the two-cycle window of a single request.

// File: rtl/xpt_pkg.sv
package xpt_pkg;

  typedef enum logic [1:0] {
    XPT_OK       = 2'd0,
    XPT_PFAULT   = 2'd1,
    XPT_NOXLAT   = 2'd2,
    XPT_BADENTRY = 2'd3
  } xpt_exc_e;

endpackage

// File: rtl/xpt_ea.sv
module xpt_ea #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12
) (
  input  logic [VA_W-1:0]           base_i,
  input  logic [VA_W-1:0]           ofs_i,
  output logic [VA_W-PAGE_BITS-1:0] vpn_o,
  output logic [PAGE_BITS-1:0]      pofs_o,
  output logic [VA_W-1:0]           flat_o
);

  // Page number: true add of the upper fields only.
  // Offset: one operand has zero low bits, so OR needs no carry chain.
  always_comb begin
    vpn_o  = base_i[VA_W-1:PAGE_BITS] + ofs_i[VA_W-1:PAGE_BITS];
    pofs_o = base_i[PAGE_BITS-1:0] | ofs_i[PAGE_BITS-1:0];
    flat_o = base_i + ofs_i;
  end

endmodule

// File: rtl/xpt_itlb.sv
module xpt_itlb #(
  parameter int ENTRIES = 4,
  parameter int VPN_W   = 20,
  parameter int FRAME_W = 18,
  localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_we,
  input  logic [SLOT_W-1:0]  fill_slot,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic               fill_mapped,
  input  logic               fill_xlated,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic [VPN_W-1:0]   lk_vpn,
  output logic               lk_hit,
  output logic               lk_mapped,
  output logic               lk_xlated,
  output logic [FRAME_W-1:0] lk_frame
);

  logic [ENTRIES-1:0] vld_q;
  logic [ENTRIES-1:0] map_q;
  logic [ENTRIES-1:0] xl_q;
  logic [VPN_W-1:0]   tag_q [ENTRIES];
  logic [FRAME_W-1:0] frm_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic slot_we;
    assign slot_we = fill_we && (fill_slot == SLOT_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
      end else if (slot_we) begin
        vld_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (slot_we) begin
        tag_q[g] <= fill_vpn;
        map_q[g] <= fill_mapped;
        xl_q[g]  <= fill_xlated;
        frm_q[g] <= fill_frame;
      end
    end
  end

  // Walk from the top slot down so the lowest matching slot wins.
  always_comb begin
    lk_hit    = 1'b0;
    lk_mapped = 1'b0;
    lk_xlated = 1'b0;
    lk_frame  = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (vld_q[i] && (tag_q[i] == lk_vpn)) begin
        lk_hit    = 1'b1;
        lk_mapped = map_q[i];
        lk_xlated = xl_q[i];
        lk_frame  = frm_q[i];
      end
    end
  end

  assert_fill_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |=> vld_q[$past(fill_slot)]);

endmodule

// File: rtl/xpt_resolve.sv
module xpt_resolve #(
  parameter int RA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_fetch,
  input  logic              in_bypass,
  input  logic              in_miss,
  input  xpt_pkg::xpt_exc_e in_exc,
  input  logic [RA_W-1:0]   in_addr,
  input  logic              entry_mark,
  output logic              out_valid,
  output logic [RA_W-1:0]   out_addr,
  output xpt_pkg::xpt_exc_e out_exc,
  output logic              out_miss
);
  import xpt_pkg::*;

  xpt_exc_e exc_d;
  logic     byp_q;

  // Late check: the marker arrives in the cycle after the optimistic fetch.
  always_comb begin
    exc_d = in_exc;
    if (in_fetch && !in_bypass && !entry_mark) begin
      exc_d = XPT_BADENTRY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      out_addr <= in_addr;
      out_exc  <= exc_d;
      out_miss <= in_miss;
      byp_q    <= in_bypass;
    end
  end

  assert_miss_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_miss) |-> (out_exc == XPT_OK && out_addr == '0));

  assert_bad_after_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_exc == XPT_BADENTRY) |-> $past(in_fetch && !entry_mark));

  assert_bypass_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && byp_q) |-> (out_exc == XPT_OK && !out_miss));

endmodule

// File: rtl/xpage_target_unit.sv
module xpage_target_unit #(
  parameter int VA_W      = 32,
  parameter int RA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int LOG2N     = 2,
  parameter int ENTRIES   = 4,
  localparam int VPN_W    = VA_W - PAGE_BITS,
  localparam int IDX_W    = PAGE_BITS + LOG2N,
  localparam int FRAME_W  = RA_W - IDX_W,
  localparam int SLOT_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_bypass,
  input  logic [VA_W-1:0]    req_base,
  input  logic [VA_W-1:0]    req_ofs,
  input  logic               fill_we,
  input  logic [SLOT_W-1:0]  fill_slot,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic               fill_mapped,
  input  logic               fill_xlated,
  input  logic [FRAME_W-1:0] fill_frame,
  output logic               fetch_valid,
  output logic [RA_W-1:0]    fetch_addr,
  output logic [IDX_W-1:0]   fetch_index,
  input  logic               entry_mark,
  output logic               done_valid,
  output logic [RA_W-1:0]    done_addr,
  output logic [1:0]         done_exc,
  output logic               done_miss
);
  import xpt_pkg::*;

  logic [VPN_W-1:0]     vpn;
  logic [PAGE_BITS-1:0] pofs;
  logic [VA_W-1:0]      flat;
  logic                 hit, mapped, xlated;
  logic [FRAME_W-1:0]   frame;

  xpt_ea #(.VA_W(VA_W), .PAGE_BITS(PAGE_BITS)) u_ea (
    .base_i (req_base),
    .ofs_i  (req_ofs),
    .vpn_o  (vpn),
    .pofs_o (pofs),
    .flat_o (flat)
  );

  xpt_itlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .FRAME_W(FRAME_W)) u_itlb (
    .clk         (clk),
    .rst_n       (rst_n),
    .fill_we     (fill_we),
    .fill_slot   (fill_slot),
    .fill_vpn    (fill_vpn),
    .fill_mapped (fill_mapped),
    .fill_xlated (fill_xlated),
    .fill_frame  (fill_frame),
    .lk_vpn      (vpn),
    .lk_hit      (hit),
    .lk_mapped   (mapped),
    .lk_xlated   (xlated),
    .lk_frame    (frame)
  );

  // Stage 1: next state
  logic            s1_fetch_d, s1_miss_d;
  xpt_exc_e        s1_exc_d;
  logic [RA_W-1:0] s1_addr_d;

  always_comb begin
    s1_fetch_d = 1'b0;
    s1_miss_d  = 1'b0;
    s1_exc_d   = XPT_OK;
    s1_addr_d  = '0;
    if (req_bypass) begin
      s1_fetch_d = 1'b1;
      s1_addr_d  = RA_W'(flat);
    end else if (!hit) begin
      s1_miss_d  = 1'b1;
    end else if (!mapped) begin
      s1_exc_d   = XPT_PFAULT;
    end else if (!xlated) begin
      s1_exc_d   = XPT_NOXLAT;
    end else begin
      s1_fetch_d = 1'b1;
      s1_addr_d  = {frame, pofs, {LOG2N{1'b0}}};
    end
  end

  // Stage 1: registers
  logic            s1_valid_q, s1_fetch_q, s1_miss_q, s1_byp_q;
  xpt_exc_e        s1_exc_q;
  logic [RA_W-1:0] s1_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= req_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (req_valid) begin
      s1_fetch_q <= s1_fetch_d;
      s1_miss_q  <= s1_miss_d;
      s1_byp_q   <= req_bypass;
      s1_exc_q   <= s1_exc_d;
      s1_addr_q  <= s1_addr_d;
    end
  end

  assign fetch_valid = s1_valid_q && s1_fetch_q;
  assign fetch_addr  = s1_addr_q;
  assign fetch_index = s1_addr_q[IDX_W-1:0];

  xpt_exc_e out_exc;

  xpt_resolve #(.RA_W(RA_W)) u_resolve (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (s1_valid_q),
    .in_fetch   (s1_fetch_q),
    .in_bypass  (s1_byp_q),
    .in_miss    (s1_miss_q),
    .in_exc     (s1_exc_q),
    .in_addr    (s1_addr_q),
    .entry_mark (entry_mark),
    .out_valid  (done_valid),
    .out_addr   (done_addr),
    .out_exc    (out_exc),
    .out_miss   (done_miss)
  );

  assign done_exc = out_exc;

  assert_two_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> $past(req_valid, 2));

  assert_fetch_not_miss_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> !done_miss);

endmodule

// File: tb/xpage_target_unit_tb.sv
module xpage_target_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_bypass = 1'b0;
  logic [31:0] req_base = '0, req_ofs = '0;
  logic        fill_we = 1'b0;
  logic [1:0]  fill_slot = '0;
  logic [19:0] fill_vpn = '0;
  logic        fill_mapped = 1'b0, fill_xlated = 1'b0;
  logic [17:0] fill_frame = '0;
  logic        fetch_valid;
  logic [31:0] fetch_addr;
  logic [13:0] fetch_index;
  logic        entry_mark = 1'b0;
  logic        done_valid;
  logic [31:0] done_addr;
  logic [1:0]  done_exc;
  logic        done_miss;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // bench-side model of buffer contents
  bit          m_vld [4];
  logic [19:0] m_vpn [4];
  bit          m_map [4];
  bit          m_xl  [4];
  logic [17:0] m_frm [4];

  always #5 clk = ~clk;

  xpage_target_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_bypass(req_bypass),
    .req_base(req_base), .req_ofs(req_ofs),
    .fill_we(fill_we), .fill_slot(fill_slot), .fill_vpn(fill_vpn),
    .fill_mapped(fill_mapped), .fill_xlated(fill_xlated), .fill_frame(fill_frame),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_index(fetch_index),
    .entry_mark(entry_mark),
    .done_valid(done_valid), .done_addr(done_addr),
    .done_exc(done_exc), .done_miss(done_miss)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_set(input int s, input logic [19:0] v, input bit mp,
                           input bit xl, input logic [17:0] fr);
    m_vld[s] = 1'b1; m_vpn[s] = v; m_map[s] = mp; m_xl[s] = xl; m_frm[s] = fr;
  endtask

  task automatic drive_fill(input int s, input logic [19:0] v, input bit mp,
                            input bit xl, input logic [17:0] fr);
    fill_we = 1'b1; fill_slot = 2'(s); fill_vpn = v;
    fill_mapped = mp; fill_xlated = xl; fill_frame = fr;
  endtask

  task automatic do_fill(input int s, input logic [19:0] v, input bit mp,
                         input bit xl, input logic [17:0] fr);
    @(negedge clk);
    drive_fill(s, v, mp, xl, fr);
    @(negedge clk);
    fill_we = 1'b0;
    model_set(s, v, mp, xl, fr);
  endtask

  // One request; fill_we, if already raised by the caller, lands in the same cycle.
  task automatic run(input logic [31:0] b, input logic [31:0] o, input bit byp,
                     input bit mark, input string tag, input bit pre_fill);
    logic [19:0] vpn;
    logic [11:0] po;
    logic [31:0] eaddr;
    bit          efetch, emiss;
    logic [1:0]  eexc;
    int          hs;
    vpn = b[31:12] + o[31:12];
    po  = b[11:0] | o[11:0];
    efetch = 0; emiss = 0; eexc = 2'd0; eaddr = '0;
    hs = -1;
    for (int i = 3; i >= 0; i--) if (m_vld[i] && m_vpn[i] == vpn) hs = i;
    if (byp) begin
      efetch = 1; eaddr = b + o;
    end else if (hs < 0) begin
      emiss = 1;
    end else if (!m_map[hs]) begin
      eexc = 2'd1;
    end else if (!m_xl[hs]) begin
      eexc = 2'd2;
    end else begin
      efetch = 1;
      eaddr = (32'(m_frm[hs]) << 14) | (32'(po) << 2);
      eexc = mark ? 2'd0 : 2'd3;
    end
    if (!pre_fill) @(negedge clk);
    req_valid = 1'b1; req_base = b; req_ofs = o; req_bypass = byp;
    @(negedge clk);
    req_valid = 1'b0; fill_we = 1'b0;
    entry_mark = mark;
    chk(fetch_valid == efetch, {tag, " R4 fetch_valid"}, 64'(fetch_valid), 64'(efetch));
    if (efetch) begin
      chk(fetch_addr == eaddr, {tag, " R3 fetch_addr"}, 64'(fetch_addr), 64'(eaddr));
      chk(fetch_index == eaddr[13:0], {tag, " R3 fetch_index"},
          64'(fetch_index), 64'(eaddr[13:0]));
    end
    @(negedge clk);
    entry_mark = 1'b0;
    chk(done_valid == 1'b1, {tag, " R4 done_valid"}, 64'(done_valid), 64'd1);
    chk(done_exc == eexc, {tag, " done_exc"}, 64'(done_exc), 64'(eexc));
    chk(done_miss == emiss, {tag, " done_miss"}, 64'(done_miss), 64'(emiss));
    chk(done_addr == eaddr, {tag, " done_addr"}, 64'(done_addr), 64'(eaddr));
  endtask

  initial begin
    for (int i = 0; i < 4; i++) m_vld[i] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(fetch_valid == 1'b0, "R1 fetch_valid after reset", 64'(fetch_valid), 64'd0);
    chk(done_valid == 1'b0, "R1 done_valid after reset", 64'(done_valid), 64'd0);
    run(32'h0001_2000, 32'h0000_0340, 0, 1, "R1 R5 empty buffer miss", 0);

    // R9: bypass with an empty buffer and a low marker
    run(32'h1234_5000, 32'h0000_0abc, 1, 0, "R9 bypass empty", 0);
    run(32'hffff_f800, 32'h0000_0c00, 1, 0, "R9 bypass wrap sum", 0);

    // Fill the four slots: good, unmapped, untranslated, unmapped+untranslated
    do_fill(0, 20'h00012, 1, 1, 18'h2_0801);
    do_fill(1, 20'h00345, 0, 1, 18'h0_0077);
    do_fill(2, 20'h00abc, 1, 0, 18'h1_1111);
    do_fill(3, 20'hfffff, 0, 0, 18'h3_ffff);

    // R2 R3 R8 sweep of page offsets, low bits from base or from offset
    for (int k = 0; k < 24; k++) begin
      logic [11:0] p;
      p = (k == 0) ? 12'h000 : (k == 1) ? 12'hfff : (k == 2) ? 12'h001 :
          (k == 3) ? 12'h800 : 12'(k * 12'h0a7);
      run(32'h0001_0000 | 32'(p), 32'h0000_2000, 0, k[0], "R3 R8 low bits in base", 0);
      run(32'h0001_2000, 32'(p), 0, !k[0], "R3 R8 low bits in offset", 0);
    end
    // R2: both low fields nonzero combine by OR (0x011|0x001 = 0x011)
    run(32'h0000_5011, 32'h0000_d001, 0, 1, "R2 or of low bits", 0);
    // R2: page number from upper add only (0x12 = 0x0f + 0x03)
    run(32'h0000_f000, 32'h0000_3fff, 0, 1, "R2 upper add", 0);

    // R6 page fault regardless of translated flag or marker
    run(32'h0034_5000, 32'h0000_0010, 0, 1, "R6 unmapped translated", 0);
    run(32'hffff_f000, 32'h0000_0ffc, 0, 0, "R6 unmapped untranslated", 0);
    // R7 translation missing
    run(32'h00ab_c000, 32'h0000_0444, 0, 1, "R7 untranslated", 0);
    run(32'h00ab_0000, 32'h0000_cfff, 0, 0, "R7 untranslated marker low", 0);
    // R5 miss with a full buffer
    run(32'h0777_7000, 32'h0000_0001, 0, 1, "R5 full buffer miss", 0);
    // R9 bypass on a page that would fault
    run(32'h0034_5000, 32'h0000_0010, 1, 0, "R9 bypass faulting page", 0);

    // R10 same-cycle fill sees old content: slot 2 becomes good now
    @(negedge clk);
    drive_fill(2, 20'h00abc, 1, 1, 18'h0_0abc);
    run(32'h00ab_c000, 32'h0000_0123, 0, 1, "R10 old content same cycle", 1);
    model_set(2, 20'h00abc, 1, 1, 18'h0_0abc);
    run(32'h00ab_c000, 32'h0000_0123, 0, 1, "R10 new content after fill", 0);
    // R10 duplicate page: slot 3 overwritten to match slot 0, slot 0 wins
    do_fill(3, 20'h00012, 1, 1, 18'h1_5555);
    run(32'h0001_2000, 32'h0000_0fff, 0, 1, "R10 lowest slot wins", 0);
    // R10 overwrite slot 0, slot 3 now answers for the page
    do_fill(0, 20'h00999, 1, 0, 18'h0_0000);
    run(32'h0001_2000, 32'h0000_0fff, 0, 1, "R10 overwritten slot", 0);
    run(32'h0099_9000, 32'h0000_0000, 0, 1, "R10 R7 refilled slot", 0);

    @(negedge clk);
    chk(done_valid == 1'b0, "R4 done_valid idle", 64'(done_valid), 64'd0);
    chk(fetch_valid == 1'b0, "R4 fetch_valid idle", 64'(fetch_valid), 64'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule